// File: doc/BRIEF.md
# Serial Converter Command and Readout Port

This block is the digital side of a successive-approximation converter's serial port, as a bus host sees it. The host lowers an active-low select, toggles a serial clock and sends an 8-bit control word on a data line. The block answers by shifting a conversion result out on a data output. A parallel input, held by the surrounding logic in place of an analog core, supplies the value that is shifted out. Every pin is sampled by a faster system clock through synchronisers, so all behaviour is counted in serial-clock edges as seen after synchronisation. Three-state behaviour is shown by output-enable pins.

While select stays low, the block keeps looking for start bits. After each control word it ignores the data line for a short lockout that depends on the mode. Once the lockout ends, a new control word may be sent while the previous result is still being read out, so a host can run conversions back to back in fewer than 24 serial clocks. The sample port has no handshake and no back-pressure: the value present at the serial-clock rising edge that ends a control word is the one converted.

Top module: `sadc_port`

## Requirements
- R1: After reset and while select is high, dout_oe and busy_oe are low and dout and busy are 0. While select is low, both enables are high.
- R2: A control word begins only on a serial-clock rising edge where din is 1, no word is being received and no lockout is running. That edge and the next seven rising edges give the eight word bits, first bit most significant, so the start bit is bit 7.
- R3: With no start bit, no conversion occurs: busy stays 0 and dout stays 0.
- R4: While a control word is being received and no readout is pending, dout is 0. In a single frame dout is 0 at rising edges 1 to 9.
- R5: busy goes high after the 8th rising edge of a control word and goes low on the 9th falling edge, so it reads 1 only at rising edge 9.
- R6: The result MSB is launched on the 9th falling edge and is valid at rising edge 10. In a 24-clock frame the host sees 9 zeros, 12 result bits MSB first and 3 zeros. The sample is captured at the 8th rising edge.
- R7: Bit 3 of the control word picks the mode. With 1 (8-bit), only the top 8 result bits are sent, at rising edges 10 to 17, followed by zeros. With 0 (12-bit), all 12 bits are sent.
- R8: Raising select drops both enables, aborts any word or readout in progress and clears dout and busy. Serial clock and din have no effect while select is high.
- R9: With select held low, a start bit after a completed frame opens a new frame without a new select cycle.
- R10: In 12-bit mode a start bit on the 7 rising edges after a control word is ignored. One on the 8th rising edge is accepted.
- R11: In 8-bit mode a start bit on the 3 rising edges after a control word is ignored. One on the 4th rising edge is accepted.
- R12: A control word accepted during a readout does not cut that readout short. Its own result follows its own 9th falling edge, which gives cycles shorter than 24 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data, sampled on rising edges |
| sample_in | input | RES_W (12) | Result value standing in for the analog core |
| dout | output | 1 | Serial result data, changed on falling edges |
| dout_oe | output | 1 | Drive enable for dout (low means high impedance) |
| busy | output | 1 | Conversion-in-progress flag |
| busy_oe | output | 1 | Drive enable for busy (low means high impedance) |

## Verification
The bench checks the lockout boundaries in both modes. It places ones on the ignored edges and a second word on the first allowed edge. If the window were one edge short or long, the second word would be lost or misframed, and busy and the data would appear at the wrong edges. Overlapped frames are compared edge by edge, so a design that reloaded the shifter too early, or forgot the skipped falling edge after a reload, would shift the second result by one position. The tests of abort and of activity while select is high catch leftover data or a word latched while deselected. A mis-indexed mode bit shows up as 12 bits sent when 8 were asked for.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int unsigned SADC_RES_W  = 12;
  localparam int unsigned SADC_CMD_W  = 8;
  localparam int unsigned SADC_MODE_B = 3;
  localparam int unsigned SADC_SHORT  = 8;
  localparam int unsigned SADC_LOCK12 = 7;
  localparam int unsigned SADC_LOCK8  = 3;

  typedef enum logic [1:0] {
    PIN_CS   = 2'd0,
    PIN_SCLK = 2'd1,
    PIN_DIN  = 2'd2
  } sadc_pin_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned      W       = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/sadc_cmd_rx.sv
module sadc_cmd_rx #(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned MODE_B = 3,
  parameter int unsigned LOCK12 = 7,
  parameter int unsigned LOCK8  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sclk_rise,
  input  logic din_s,
  output logic cmd_done,
  output logic cmd_short
);
  localparam int unsigned CNT_W  = $clog2(CMD_W);
  localparam int unsigned LMAX   = (LOCK12 > LOCK8) ? LOCK12 : LOCK8;
  localparam int unsigned LOCK_W = $clog2(LMAX + 1);
  localparam int unsigned HIST_W = (MODE_B > 0) ? MODE_B : 1;

  logic              active;
  logic [CNT_W-1:0]  bitcnt;
  logic [HIST_W-1:0] hist;
  logic [LOCK_W-1:0] lock;
  logic              mode_now;

  // mode bit of the word completing on this edge
  assign mode_now = (MODE_B == 0) ? din_s : hist[HIST_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bitcnt    <= '0;
      hist      <= '0;
      lock      <= '0;
      cmd_done  <= 1'b0;
      cmd_short <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (clr) begin
        active <= 1'b0;
        bitcnt <= '0;
        lock   <= '0;
      end else if (sclk_rise) begin
        if (active) begin
          hist <= HIST_W'({hist, din_s});
          if (bitcnt == CNT_W'(CMD_W - 1)) begin
            active    <= 1'b0;
            bitcnt    <= '0;
            cmd_done  <= 1'b1;
            cmd_short <= mode_now;
            lock      <= mode_now ? LOCK_W'(LOCK8) : LOCK_W'(LOCK12);
          end else begin
            bitcnt <= bitcnt + CNT_W'(1);
          end
        end else if (lock != '0) begin
          lock <= lock - LOCK_W'(1);
        end else if (din_s) begin
          active <= 1'b1;
          bitcnt <= CNT_W'(1);
          hist   <= HIST_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sadc_readout.sv
module sadc_readout #(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             short_mode,
  input  logic [RES_W-1:0] sample,
  input  logic             sclk_fall,
  output logic             dout,
  output logic             busy
);
  localparam int unsigned LEFT_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] SHORT_MASK =
    ~((RES_W'(1) << (RES_W - SHORT_W)) - RES_W'(1));

  logic [RES_W-1:0]  sh;
  logic [LEFT_W-1:0] left;
  logic              skip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      skip <= 1'b0;
      busy <= 1'b0;
      dout <= 1'b0;
    end else if (clr) begin
      sh   <= '0;
      left <= '0;
      skip <= 1'b0;
      busy <= 1'b0;
      dout <= 1'b0;
    end else if (load) begin
      sh   <= short_mode ? (sample & SHORT_MASK) : sample;
      left <= '0;
      skip <= 1'b1;
      busy <= 1'b1;
    end else if (sclk_fall) begin
      if (skip) begin
        skip <= 1'b0;
      end else if (busy) begin
        busy <= 1'b0;
        dout <= sh[RES_W-1];
        sh   <= sh << 1;
        left <= LEFT_W'(RES_W - 1);
      end else if (left != '0) begin
        dout <= sh[RES_W-1];
        sh   <= sh << 1;
        left <= left - LEFT_W'(1);
      end else begin
        dout <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int unsigned RES_W   = SADC_RES_W,
  parameter int unsigned CMD_W   = SADC_CMD_W,
  parameter int unsigned MODE_B  = SADC_MODE_B,
  parameter int unsigned SHORT_W = SADC_SHORT,
  parameter int unsigned LOCK12  = SADC_LOCK12,
  parameter int unsigned LOCK8   = SADC_LOCK8,
  parameter int unsigned STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] sample_in,
  output logic             dout,
  output logic             dout_oe,
  output logic             busy,
  output logic             busy_oe
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pins_s;
  logic cs_s, sclk_s, din_s, sclk_q;
  logic sclk_rise, sclk_fall;
  logic cmd_done, cmd_short;

  sadc_sync #(.W(NPIN), .STAGES(STAGES), .RST_VAL(NPIN'(1) << PIN_CS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({din, sclk, cs_n}),
    .sync_out (pins_s)
  );

  assign cs_s   = pins_s[PIN_CS];
  assign sclk_s = pins_s[PIN_SCLK];
  assign din_s  = pins_s[PIN_DIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_q & ~cs_s;

  sadc_cmd_rx #(.CMD_W(CMD_W), .MODE_B(MODE_B), .LOCK12(LOCK12), .LOCK8(LOCK8)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cs_s),
    .sclk_rise (sclk_rise),
    .din_s     (din_s),
    .cmd_done  (cmd_done),
    .cmd_short (cmd_short)
  );

  sadc_readout #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_ro (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cs_s),
    .load       (cmd_done),
    .short_mode (cmd_short),
    .sample     (sample_in),
    .sclk_fall  (sclk_fall),
    .dout       (dout),
    .busy       (busy)
  );

  assign dout_oe = ~cs_s;
  assign busy_oe = ~cs_s;
endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sclk_fall,
  input logic cmd_done,
  input logic dout,
  input logic busy
);
  // R8: deselect clears the result path on the next cycle
  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!busy && !dout));

  // R5: busy only rises right after a completed control word
  assert_busy_after_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_done));

  // R5: busy only falls on a serial falling edge or deselect
  assert_busy_ends_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(sclk_fall) || $past(cs_s)));

  // R6: dout moves only on serial falling edges or deselect
  assert_dout_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(sclk_fall) || $past(cs_s)));

  // R2: no control word completes while deselected
  assert_no_word_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !$past(cs_s));
endmodule

bind sadc_port sadc_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .sclk_fall (sclk_fall),
  .cmd_done  (cmd_done),
  .dout      (dout),
  .busy      (busy)
);

// File: tb/sadc_port_tb.sv
module sadc_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] sample_in = '0;
  logic        dout, dout_oe, busy, busy_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] dseq, bseq;

  always #10 clk = ~clk;

  sadc_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe),
    .busy(busy), .busy_oe(busy_oe)
  );

  // {control word, sample}
  localparam logic [19:0] VEC [6] = '{
    {8'h80, 12'hA5C}, {8'h88, 12'hA5C}, {8'hFF, 12'h001},
    {8'hC7, 12'hFFF}, {8'h8B, 12'h800}, {8'hB4, 12'h3C3}
  };
  localparam logic [23:0] BUSY24 = 24'h008000;

  function automatic logic [23:0] frame24(input logic [7:0] cmd, input logic [11:0] s);
    logic [11:0] d;
    d = cmd[3] ? (s & 12'hFF0) : s;
    return {9'b0, d, 3'b0};
  endfunction

  function automatic logic [63:0] place(input logic [23:0] f, input int r);
    return {f, 40'b0} >> (r - 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] pat, input int n);
    dseq = '0;
    bseq = '0;
    for (int k = 1; k <= n; k++) begin
      din = pat[64-k];
      repeat (6) @(negedge clk);
      dseq[64-k] = dout;
      bseq[64-k] = busy;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    din = 1'b0;
  endtask

  function automatic logic [63:0] topmask(input int n);
    return ~64'b0 << (64 - n);
  endfunction

  task automatic select(input logic v);
    cs_n = v;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] f1, f2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {60'b0, dout_oe, busy_oe, dout, busy}, 64'h0);
    select(1'b0);
    chk("R1 enables when selected", {62'b0, dout_oe, busy_oe}, 64'h3);
    select(1'b1);

    // table of single frames: R2 R4 R5 R6 R7
    foreach (VEC[i]) begin
      sample_in = VEC[i][11:0];
      select(1'b0);
      run({VEC[i][19:12], 56'b0}, 24);
      select(1'b1);
      f1 = frame24(VEC[i][19:12], VEC[i][11:0]);
      chk(VEC[i][15] ? "R7 R2 short frame" : "R6 R2 full frame",
          dseq & topmask(24), {f1, 40'b0});
      chk("R4 zeros during word", {55'b0, dseq[63:55]}, 64'h0);
      chk("R5 busy window", bseq & topmask(24), {BUSY24, 40'b0});
    end

    sample_in = 12'hB6D;

    // R3 no start bit
    select(1'b0);
    run(64'h0, 30);
    chk("R3 dout idle", dseq, 64'h0);
    chk("R3 busy idle", bseq, 64'h0);
    select(1'b1);

    // R9 continuous hunting, second word 8-bit at rise 25
    select(1'b0);
    run({8'h80, 16'h0, 8'h88, 32'h0}, 52);
    select(1'b1);
    chk("R9 two frames data",
        dseq & topmask(52),
        (place(frame24(8'h80, sample_in), 1) | place(frame24(8'h88, sample_in), 25)) & topmask(52));
    chk("R9 two frames busy", bseq & topmask(52),
        (place(BUSY24, 1) | place(BUSY24, 25)) & topmask(52));

    // R10 ones inside 12-bit lockout are ignored
    select(1'b0);
    run({8'h80, 7'h7F, 49'h0}, 40);
    select(1'b1);
    chk("R10 lockout ignores ones", dseq & topmask(40),
        place(frame24(8'h80, sample_in), 1) & topmask(40));
    chk("R10 no second busy", bseq & topmask(40), place(BUSY24, 1) & topmask(40));

    // R10 R12 word on 8th edge after a 12-bit word overlaps readout
    select(1'b0);
    run({8'h80, 7'h0, 8'h88, 41'h0}, 40);
    select(1'b1);
    f1 = frame24(8'h80, sample_in);
    f2 = frame24(8'h88, sample_in);
    chk("R12 overlapped data 12-bit", dseq & topmask(40),
        (place(f1, 1) | place(f2, 16)) & topmask(40));
    chk("R10 accepted at 8th edge busy", bseq & topmask(40),
        (place(BUSY24, 1) | place(BUSY24, 16)) & topmask(40));

    // R11 R12 8-bit lockout: ones on 3 edges ignored, word on 4th
    select(1'b0);
    run({8'h88, 3'b111, 8'h80, 45'h0}, 40);
    select(1'b1);
    f1 = frame24(8'h88, sample_in);
    f2 = frame24(8'h80, sample_in);
    chk("R11 overlapped data 8-bit", dseq & topmask(40),
        (place(f1, 1) | place(f2, 12)) & topmask(40));
    chk("R11 accepted at 4th edge busy", bseq & topmask(40),
        (place(BUSY24, 1) | place(BUSY24, 12)) & topmask(40));

    // R8 abort mid readout, activity while deselected ignored
    select(1'b0);
    run({8'h80, 56'h0}, 14);
    chk("R8 partial readout before abort", dseq & topmask(14),
        place(frame24(8'h80, sample_in), 1) & topmask(14));
    select(1'b1);
    chk("R8 enables dropped", {62'b0, dout_oe, busy_oe}, 64'h0);
    run(~64'h0, 16);
    chk("R8 enables stay low", {62'b0, dout_oe, busy_oe}, 64'h0);
    select(1'b0);
    chk("R8 no leftover after reselect", {62'b0, dout, busy}, 64'h0);
    run(64'h0, 24);
    chk("R8 nothing latched while deselected", dseq | bseq, 64'h0);
    select(1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule